// File: doc/BRIEF.md
# Loadable 32-State Clock Phase Generator

This block is a free-running 32-state phase counter clocked by the fast converter clock. The counter bits give the divided clocks that the data path runs from. Tap k of the counter toggles every 2^k fast-clock cycles, so every tap has a 50% duty cycle. A mode input picks one tap as the selected divided clock for the current interpolation setting.

A single-cycle initialization pulse makes a programmable 5-bit start value the counter's next state. This sets the phase of all divided clocks relative to an external sync event. Raising the start value by one moves the internal clocks one fast-clock period earlier. The first pulse after reset only aligns the counter. Later pulses normally arrive a whole number of 32-cycle periods apart, and such a pulse reloads the value the counter was about to reach anyway, so the clocks run on without disturbance. A pulse whose start value differs from the counter's natural next state sets a sticky misalignment flag. The flag stays set until a clear input removes it.

Top module: `clk_phase_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the state output is 0, the aligned output is 0 and the misaligned output is 0.
- R2: In any cycle without an initialization pulse the state output becomes the previous state plus one, modulo 32, so state 31 is followed by state 0.
- R3: At a clock edge where the initialization pulse is high, the state output takes the value on the start-state input.
- R4: The first initialization pulse after reset sets the aligned output to 1 and does not set the misaligned output, whatever the counter's phase.
- R5: When aligned, a pulse whose start value equals the previous state plus one (mod 32) leaves the misaligned output unchanged and the state sequence unbroken.
- R6: When aligned, a pulse whose start value differs from the previous state plus one (mod 32) sets the misaligned output. The output stays 1 across later cycles until a clear is seen.
- R7: A high clear input at a clock edge drives the misaligned output to 0. If a misaligned pulse arrives at the same edge, setting the flag takes priority.
- R8: Output bit k of the tap bus equals bit k of the state, which gives divided clocks with periods of 2, 4, 8, 16 and 32 fast-clock cycles.
- R9: The selected clock equals state bit 0, 1, 2, 3 or 4 for mode codes 0 (1x), 1 (2x), 2 (4x), 3 (8x) and 4 (8x with zero stuffing). Mode codes 5 to 7 are invalid and hold the selected clock low.
- R10: A change on the start-state input with no pulse has no effect on the state sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initPulse | input | 1 | Single-cycle initialization pulse |
| startState | input | 5 | Value loaded as next state on a pulse |
| modeSel | input | 3 | Interpolation mode code selecting the divided clock |
| errClear | input | 1 | Clears the misalignment flag |
| state | output | 5 | Current phase counter value |
| taps | output | 5 | All divided clocks, tap k = state bit k |
| selClk | output | 1 | Divided clock for the selected mode |
| aligned | output | 1 | High once a pulse has aligned the counter |
| misaligned | output | 1 | Sticky flag for an out-of-phase pulse |

## Verification
Every registered result (state, aligned, misaligned) changes at the first rising edge after the stimulus that causes it. The taps and the selected clock follow the state combinationally, in that same cycle. The bench changes inputs one nanosecond after a rising edge and reads the outputs one nanosecond after the next rising edge, so each check sees exactly one edge of effect. The long runs for wrap-around, periodic realignment and flag stickiness count edges from a known loaded state, so the expected phase at every pulse is fixed ahead of time.

// File: rtl/clk_phase_pkg.sv
`timescale 1ns/1ps
package clk_phase_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic load;     // take the start value as the next state
    logic flagSet;  // out-of-phase pulse seen
    logic flagClr;  // request to clear the flag
  } phaseStrobe_t;

  // Interpolation mode codes; the code doubles as the tap index
  typedef enum logic [2:0] {
    MODE_X1  = 3'd0,
    MODE_X2  = 3'd1,
    MODE_X4  = 3'd2,
    MODE_X8  = 3'd3,
    MODE_X8Z = 3'd4
  } interpMode_t;

endpackage

// File: rtl/phase_datapath.sv
`timescale 1ns/1ps
module phase_datapath
  import clk_phase_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter int MODE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  phaseStrobe_t       strobe,
  input  logic [STATE_W-1:0] startState,
  input  logic [MODE_W-1:0]  modeSel,
  output logic [STATE_W-1:0] cnt,
  output logic               selClk,
  output logic               phaseHit
);

  localparam int NUM_STATES = 1 << STATE_W;
  localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

  logic [STATE_W-1:0] cntInc;

  assign cntInc   = cnt + ONE;          // wraps naturally at NUM_STATES
  assign phaseHit = (cntInc == startState);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= startState;
    end else begin
      cnt <= cntInc;
    end
  end

  // Tap mux: codes beyond the last tap give a low clock
  always_comb begin
    selClk = 1'b0;
    for (int k = 0; k < STATE_W; k++) begin
      if (modeSel == MODE_W'(k)) selClk = cnt[k];
    end
  end

  // R2: without a load the counter steps by one modulo NUM_STATES
  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (cnt == STATE_W'(($past(cnt) + 1) % NUM_STATES)));

  // R3: a load makes the start value the state
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == $past(startState)));

endmodule

// File: rtl/phase_control.sv
`timescale 1ns/1ps
module phase_control
  import clk_phase_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         initPulse,
  input  logic         errClear,
  input  logic         phaseHit,
  output phaseStrobe_t strobe,
  output logic         aligned,
  output logic         misaligned
);

  always_comb begin
    strobe.load    = initPulse;
    strobe.flagSet = initPulse && aligned && !phaseHit;
    strobe.flagClr = errClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
    end else if (initPulse) begin
      aligned <= 1'b1;
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misaligned <= 1'b0;
    end else if (strobe.flagSet) begin
      misaligned <= 1'b1;
    end else if (strobe.flagClr) begin
      misaligned <= 1'b0;
    end
  end

  // R4: the aligning pulse never raises the flag
  a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (initPulse && !aligned) |=> (aligned && !misaligned));

  // R6: the flag holds without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (misaligned && !errClear) |=> misaligned);

  // R7: a clear with no pulse empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !initPulse) |=> !misaligned);

  // R5: an in-phase pulse does not change the flag
  a_r5_in_phase: assert property (@(posedge clk) disable iff (!rstN)
    (initPulse && phaseHit && !errClear) |=> $stable(misaligned));

endmodule

// File: rtl/clk_phase_gen.sv
`timescale 1ns/1ps
module clk_phase_gen
  import clk_phase_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter int MODE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initPulse,
  input  logic [STATE_W-1:0] startState,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic               errClear,
  output logic [STATE_W-1:0] state,
  output logic [STATE_W-1:0] taps,
  output logic               selClk,
  output logic               aligned,
  output logic               misaligned
);

  phaseStrobe_t       strobe;
  logic               phaseHit;
  logic [STATE_W-1:0] cnt;

  phase_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .initPulse (initPulse),
    .errClear  (errClear),
    .phaseHit  (phaseHit),
    .strobe    (strobe),
    .aligned   (aligned),
    .misaligned(misaligned)
  );

  phase_datapath #(
    .STATE_W(STATE_W),
    .MODE_W (MODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startState(startState),
    .modeSel   (modeSel),
    .cnt       (cnt),
    .selClk    (selClk),
    .phaseHit  (phaseHit)
  );

  assign state = cnt;
  assign taps  = cnt;

  // R9: invalid mode codes hold the selected clock low
  a_r9_invalid_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel > MODE_W'(STATE_W - 1)) |-> !selClk);

endmodule

// File: tb/clk_phase_gen_bench.sv
`timescale 1ns/1ps
module clk_phase_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initPulse = 1'b0;
  logic [4:0] startState = '0;
  logic [2:0] modeSel = '0;
  logic       errClear = 1'b0;
  logic [4:0] state, taps;
  logic       selClk, aligned, misaligned;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  clk_phase_gen u_clk_phase_gen (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .startState(startState),
    .modeSel(modeSel), .errClear(errClear), .state(state), .taps(taps),
    .selClk(selClk), .aligned(aligned), .misaligned(misaligned)
  );

  // {pulse, start[5], mode[3], clr, expState[5], expAligned, expMis, expSel}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 5'd5,  3'd0, 1'b0, 5'd1,  1'b0, 1'b0, 1'b1},  // R2
    {1'b1, 5'd5,  3'd1, 1'b0, 5'd5,  1'b1, 1'b0, 1'b0},  // R3 R4
    {1'b0, 5'd5,  3'd2, 1'b0, 5'd6,  1'b1, 1'b0, 1'b1},  // R9
    {1'b0, 5'd5,  3'd3, 1'b0, 5'd7,  1'b1, 1'b0, 1'b0},  // R9
    {1'b1, 5'd8,  3'd3, 1'b0, 5'd8,  1'b1, 1'b0, 1'b1},  // R5
    {1'b1, 5'd20, 3'd4, 1'b0, 5'd20, 1'b1, 1'b1, 1'b1},  // R6
    {1'b0, 5'd20, 3'd5, 1'b0, 5'd21, 1'b1, 1'b1, 1'b0},  // R9 invalid
    {1'b0, 5'd20, 3'd0, 1'b1, 5'd22, 1'b1, 1'b0, 1'b0},  // R7
    {1'b1, 5'd23, 3'd0, 1'b1, 5'd23, 1'b1, 1'b0, 1'b1},  // R5
    {1'b1, 5'd0,  3'd1, 1'b1, 5'd0,  1'b1, 1'b1, 1'b0},  // R7 set wins
    {1'b0, 5'd0,  3'd1, 1'b0, 5'd1,  1'b1, 1'b1, 1'b0}   // R6
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    initPulse = 1'b0;
    errClear = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 state", int'(state), 0);
    check("R1 aligned", int'(aligned), 0);
    check("R1 mis", int'(misaligned), 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      {initPulse, startState, modeSel, errClear} = VEC[v][17:8];
      tick();
      check($sformatf("R2/R3 state vec%0d", v), int'(state), int'(VEC[v][7:3]));
      check($sformatf("R4 aligned vec%0d", v), int'(aligned), int'(VEC[v][2]));
      check($sformatf("R5/R6/R7 mis vec%0d", v), int'(misaligned), int'(VEC[v][1]));
      check($sformatf("R9 selClk vec%0d", v), int'(selClk), int'(VEC[v][0]));
      check($sformatf("R8 taps vec%0d", v), int'(taps), int'(VEC[v][7:3]));
    end

    // R10: start value change without pulse (state 1 -> 4)
    startState = 5'd17;
    idle(3);
    check("R10 state", int'(state), 4);

    // R2: wrap-around and R8 taps at the top state
    idle(27);
    check("R2 top", int'(state), 31);
    check("R8 taps top", int'(taps), 31);
    modeSel = 3'd4;
    #1 check("R9 x8z at 31", int'(selClk), 1);
    idle(1);
    check("R2 wrap", int'(state), 0);
    check("R9 x8z at 0", int'(selClk), 0);

    // R5: periodic in-phase pulses every 32 cycles
    startState = 5'd10;
    initPulse = 1'b1;
    tick();
    check("R3 load 10", int'(state), 10);
    initPulse = 1'b0;
    errClear = 1'b1;
    tick();
    check("R7 cleared", int'(misaligned), 0);
    errClear = 1'b0;
    idle(30);
    for (int p = 0; p < 3; p++) begin
      check("R5 pre-pulse state", int'(state), 9);
      initPulse = 1'b1;
      tick();
      check("R5 state", int'(state), 10);
      check("R5 mis", int'(misaligned), 0);
      idle(31);
    end

    // R6: off-phase pulse and stickiness (state 9 -> +5 = 14)
    idle(5);
    initPulse = 1'b1;
    tick();
    check("R6 set", int'(misaligned), 1);
    check("R3 state", int'(state), 10);
    idle(40);
    check("R6 sticky", int'(misaligned), 1);

    // R1: reset mid-run, then R4 first pulse quiet
    rstN = 1'b0;
    #1;
    check("R1 state mid", int'(state), 0);
    check("R1 aligned mid", int'(aligned), 0);
    check("R1 mis mid", int'(misaligned), 0);
    tick();
    rstN = 1'b1;
    idle(7);
    startState = 5'd3;
    initPulse = 1'b1;
    tick();
    check("R4 aligned", int'(aligned), 1);
    check("R4 mis", int'(misaligned), 0);
    check("R3 state 3", int'(state), 3);
    idle(1);
    check("R2 after load", int'(state), 4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule